// File: doc/BRIEF.md
# Selectable Wiper and Data Register Bank

This block is the register back end behind a two-wire serial slave that controls four digitally set resistor channels. Each channel owns one volatile wiper register, whose value drives the channel's tap position, and four data registers that model nonvolatile storage. A small volatile status register, the route byte, decides where the channel addresses land. With its enable bit clear, channel addresses reach the wiper registers. With the bit set, they reach one chosen row of data registers.

The serial front end hands each decoded byte access to the bank as a request on a valid/ready handshake. The front end holds `req_valid` and its payload until `req_ready` is high at a rising clock edge. `req_ready` is low only while a storage commit is in progress, so during that time the front end withholds its acknowledge. Read data comes back on a one-cycle response pulse that the front end must take; the response path has no back-pressure. At the STOP condition the front end pulses `commit`. If any data register was written since the last commit, the bank enters a busy window of a fixed number of cycles that models the storage write time.

The bank also moves values into the wiper registers as a side effect of some accesses. Writing a row select with the enable bit set copies that data row into all four wipers. Reading or writing a channel's data register also loads that channel's wiper with the value.

Top module: `dcp_reg_bank`

## Requirements
- R1: After reset, all wiper outputs are 00h, the route byte reads 00h, `busy` is 0 and `req_ready` is 1.
- R2: The route byte is at address 07h. A write keeps only bits 2:0 (bit 0 = nonvolatile enable, bits 2:1 = row number) and a read returns them with bits 7:3 as zero.
- R3: With route bit 0 clear, addresses 00h–03h read and write wiper registers 0–3 whatever bits 2:1 hold, and a write changes only the addressed wiper.
- R4: With route bit 0 set, addresses 00h–03h read and write the data register of channel 0–3 in the row given by route bits 2:1.
- R5: A route write with bit 0 set loads every wiper from its data register in the row given by the written bits 2:1, visible on the outputs in the cycle after acceptance; a route write with bit 0 clear leaves all wipers unchanged.
- R6: A read or write of a channel's data register also loads that channel's wiper with the data value, and leaves the other wipers unchanged.
- R7: Addresses 04h–06h and 08h–FFh read as 00h, and writes to them change no register.
- R8: A `commit` pulse after at least one data-register write since the previous commit raises `busy` for exactly BUSY_CYCLES cycles, starting the cycle after the pulse; a `commit` with no such write leaves `busy` at 0.
- R9: While `busy` is 1, `req_ready` is 0, no request is accepted, no register changes and no response is produced.
- R10: An accepted read produces `rsp_valid` high for exactly one cycle, in the cycle after acceptance, with the read value on `rsp_data`. An accepted write produces no response.
- R11: Four writes to addresses 00h–03h accepted in consecutive cycles (a page) all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Bank can accept a request (low while busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Byte address of the access |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle |
| rsp_data | output | DW (8) | Read response data |
| commit | input | 1 | STOP-time pulse that starts a storage commit |
| busy | output | 1 | Storage commit in progress |
| wiper_flat | output | NCH*DW (32) | Wiper values, channel i in bits [i*DW +: DW] |

## Verification
The hardest case to bring about is the row copy into the wipers. It is only visible when the four rows hold distinct values in every channel, and that state can only be built through the route byte, which the bank must walk through each row. So the bench first fills all sixteen data registers with values computed from the row and channel, writing each row as a back-to-back page and committing it. Only then does it sweep all eight route values and all read paths. The busy window is reached the same way, and the bench sends requests while `busy` is high to show that nothing is accepted.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  // Kind of target an address resolves to.
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_ROUTE  = 2'd1,
    ACC_CHAN   = 2'd2,
    ACC_RSVD   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dcp_addr_decode.sv
module dcp_addr_decode
  import dcp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int NCH        = 4,
  parameter int ROUTE_ADDR = 7,
  localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0] addr,
  output acc_kind_e     kind,
  output logic [CW-1:0] chan
);
  always_comb begin
    chan = addr[CW-1:0];
    if (addr == AW'(ROUTE_ADDR))
      kind = ACC_ROUTE;
    else if (addr < AW'(NCH))
      kind = ACC_CHAN;
    else
      kind = ACC_RSVD;
  end
endmodule

// File: rtl/dcp_reg_store.sv
module dcp_reg_store
  import dcp_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NROW = 4,
  parameter int DW   = 8,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW  = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               is_write,
  input  acc_kind_e          kind,
  input  logic [CW-1:0]      chan,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               data_wr,
  output logic [NCH*DW-1:0]  wiper_flat
);
  logic [DW-1:0] wiper_q [NCH];
  logic [DW-1:0] data_q  [NCH][NROW];
  logic [RW:0]   route_q;
  logic [RW-1:0] row_sel;
  logic [RW-1:0] new_row;

  assign row_sel = route_q[RW:1];
  assign new_row = wdata[RW:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        wiper_q[i] <= '0;
        for (int r = 0; r < NROW; r++) data_q[i][r] <= '0;
      end
    end else if (fire) begin
      case (kind)
        ACC_ROUTE: if (is_write) begin
          route_q <= wdata[RW:0];
          if (wdata[0])
            for (int i = 0; i < NCH; i++) wiper_q[i] <= data_q[i][new_row];
        end
        ACC_CHAN: if (route_q[0]) begin
          if (is_write) begin
            data_q[chan][row_sel] <= wdata;
            wiper_q[chan]         <= wdata;
          end else begin
            wiper_q[chan] <= data_q[chan][row_sel];
          end
        end else if (is_write) begin
          wiper_q[chan] <= wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      ACC_ROUTE: rdata = {{(DW-RW-1){1'b0}}, route_q};
      ACC_CHAN:  rdata = route_q[0] ? data_q[chan][row_sel] : wiper_q[chan];
      default:   rdata = '0;
    endcase
  end

  assign data_wr = fire && is_write && (kind == ACC_CHAN) && route_q[0];

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign wiper_flat[g*DW +: DW] = wiper_q[g];
  end
endmodule

// File: rtl/dcp_busy_timer.sv
module dcp_busy_timer #(
  parameter int BUSY_CYCLES = 5000,
  localparam int TW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic commit,
  output logic busy
);
  logic          pending_q;
  logic [TW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      left_q    <= '0;
    end else begin
      if (busy) begin
        left_q <= left_q - 1'b1;
      end else if (commit) begin
        if (pending_q || mark) left_q <= TW'(BUSY_CYCLES);
        pending_q <= 1'b0;
      end else if (mark) begin
        pending_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcp_reg_bank.sv
module dcp_reg_bank
  import dcp_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int NROW        = 4,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int ROUTE_ADDR  = 7,
  parameter int BUSY_CYCLES = 5000,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  input  logic              commit,
  output logic              busy,
  output logic [NCH*DW-1:0] wiper_flat
);
  acc_kind_e     kind;
  logic [CW-1:0] chan;
  logic [DW-1:0] rdata;
  logic          data_wr;
  logic          fire;

  assign req_ready = !busy;
  assign fire      = req_valid && req_ready;

  dcp_addr_decode #(.AW(AW), .NCH(NCH), .ROUTE_ADDR(ROUTE_ADDR)) dec_i (
    .addr (req_addr),
    .kind (kind),
    .chan (chan)
  );

  dcp_reg_store #(.NCH(NCH), .NROW(NROW), .DW(DW)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .is_write   (req_write),
    .kind       (kind),
    .chan       (chan),
    .wdata      (req_wdata),
    .rdata      (rdata),
    .data_wr    (data_wr),
    .wiper_flat (wiper_flat)
  );

  dcp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark   (data_wr),
    .commit (commit),
    .busy   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire && !req_write;
      if (fire && !req_write) rsp_data <= rdata;
    end
  end
endmodule

// File: rtl/dcp_reg_bank_chk.sv
module dcp_reg_bank_chk #(
  parameter int NCH         = 4,
  parameter int DW          = 8,
  parameter int AW          = 8,
  parameter int ROUTE_ADDR  = 7,
  parameter int BUSY_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_data,
  input logic              commit,
  input logic              busy,
  input logic [NCH*DW-1:0] wiper_flat
);
  logic        rd_acc;
  logic        rsvd_addr;
  logic [31:0] busy_run;

  assign rd_acc    = req_valid && req_ready && !req_write;
  assign rsvd_addr = (req_addr != AW'(ROUTE_ADDR)) && (req_addr >= AW'(NCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !busy && !rsp_valid);

  assert_route_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr == AW'(ROUTE_ADDR)) |=> rsp_data[DW-1:3] == '0);

  assert_rsvd_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && rsvd_addr) |=> rsp_data == '0);

  assert_busy_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == 32'(BUSY_CYCLES));

  assert_busy_freezes_wipers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper_flat));

  assert_busy_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);

  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  assert_rsp_needs_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));
endmodule

bind dcp_reg_bank dcp_reg_bank_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .ROUTE_ADDR(ROUTE_ADDR), .BUSY_CYCLES(BUSY_CYCLES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .commit     (commit),
  .busy       (busy),
  .wiper_flat (wiper_flat)
);

// File: tb/dcp_reg_bank_tb.sv
module dcp_reg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        commit = 1'b0;
  logic        busy;
  logic [31:0] wiper_flat;

  int n_run  = 0;
  int n_fail = 0;

  logic [7:0] m_wip [4];
  logic [7:0] m_dat [4][4];
  logic [2:0] m_rt;
  bit         m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcp_reg_bank #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .commit(commit),
    .busy(busy), .wiper_flat(wiper_flat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val_of(input int row, input int ch);
    return 8'((row * 16 + ch * 3 + 1) ^ 8'h5A);
  endfunction

  task automatic check_wipers(input string req);
    for (int i = 0; i < 4; i++)
      check(wiper_flat[i*8 +: 8] == m_wip[i], req, wiper_flat[i*8 +: 8], m_wip[i]);
  endtask

  // One request; starts and ends at a falling edge.
  task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d, input string req);
    logic [7:0] exp_rd;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    exp_rd = 8'h00;
    if (a == 8'h07) begin
      exp_rd = {5'b0, m_rt};
      if (w) begin
        m_rt = d[2:0];
        if (d[0]) for (int i = 0; i < 4; i++) m_wip[i] = m_dat[i][d[2:1]];
      end
    end else if (a < 8'h04) begin
      if (m_rt[0]) begin
        exp_rd = m_dat[a][m_rt[2:1]];
        if (w) begin m_dat[a][m_rt[2:1]] = d; m_pend = 1'b1; end
        m_wip[a] = w ? d : exp_rd;
      end else begin
        exp_rd = m_wip[a];
        if (w) m_wip[a] = d;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == !w, {req, " rsp_valid"}, rsp_valid, !w);
    if (!w) check(rsp_data == exp_rd, {req, " rsp_data"}, rsp_data, exp_rd);
    check_wipers(req);
  endtask

  task automatic do_commit(input string req);
    int n;
    bit exp_busy;
    exp_busy = m_pend;
    m_pend = 1'b0;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check(busy == exp_busy, {req, " busy start"}, busy, exp_busy);
    n = 0;
    while (busy && n < 10 * BUSY) begin
      check(!req_ready, {req, " ready low while busy"}, req_ready, 0);
      n++;
      @(negedge clk);
    end
    check(n == (exp_busy ? BUSY : 0), {req, " busy length"}, n, exp_busy ? BUSY : 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    m_rt = '0; m_pend = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_wip[i] = '0;
      for (int r = 0; r < 4; r++) m_dat[i][r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check_wipers("R1 wipers");
    access(1'b0, 8'h07, 8'h00, "R1 route read");

    // R8: commit with nothing pending gives no busy
    do_commit("R8 idle commit");

    // R4 R11: fill every row as a back-to-back page, commit each (R8)
    for (int r = 0; r < 4; r++) begin
      access(1'b1, 8'h07, 8'(r * 2 + 1), "R5 select row");
      for (int c = 0; c < 4; c++) access(1'b1, 8'(c), val_of(r, c), "R11 page write");
      do_commit("R8 row commit");
    end

    // R2 R5: sweep all route values, including reserved bits set
    for (int v = 0; v < 8; v++) begin
      access(1'b1, 8'h07, 8'(v) | 8'hF0, "R5 route write copy");
      access(1'b0, 8'h07, 8'h00, "R2 route readback");
      for (int c = 0; c < 4; c++) access(1'b0, 8'(c), 8'h00, "R4 R6 channel read");
    end

    // R3: wipers written one at a time, DRSel ignored
    access(1'b1, 8'h07, 8'h06, "R3 route wipers");
    for (int c = 0; c < 4; c++) begin
      access(1'b1, 8'(c), 8'(8'hC0 + c), "R3 single wiper write");
      access(1'b0, 8'(c), 8'h00, "R3 wiper read");
    end
    do_commit("R8 no commit after wiper writes");

    // R6: data write loads only its own wiper
    access(1'b1, 8'h07, 8'h05, "R6 route row2");
    access(1'b1, 8'h02, 8'h77, "R6 data write");
    access(1'b0, 8'h01, 8'h00, "R6 data read loads wiper");
    do_commit("R8 commit after data write");

    // R7: reserved addresses
    foreach (m_wip[i]) ;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ra;
      ra = (k == 0) ? 8'h04 : (k == 1) ? 8'h05 : (k == 2) ? 8'h06 :
           (k == 3) ? 8'h08 : (k == 4) ? 8'h80 : 8'hFF;
      access(1'b1, ra, 8'hAA, "R7 reserved write");
      access(1'b0, ra, 8'h00, "R7 reserved read");
    end
    access(1'b0, 8'h07, 8'h00, "R7 route unchanged");
    for (int c = 0; c < 4; c++) access(1'b0, 8'(c), 8'h00, "R7 data unchanged");

    // R9: requests during busy are refused
    access(1'b1, 8'h00, 8'h3C, "R9 setup write");
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    m_pend = 1'b0;
    check(busy == 1'b1, "R9 busy", busy, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h03; req_wdata = 8'hEE;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R9 ready low", req_ready, 0);
    check(rsp_valid == 1'b0, "R9 no rsp", rsp_valid, 0);
    check_wipers("R9 wipers frozen");
    req_write = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 no read rsp", rsp_valid, 0);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    access(1'b0, 8'h03, 8'h00, "R9 data not written");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule